// File: doc/BRIEF.md
# Write-Only Control Group Register Target on I2C

This block is a receive-only I2C target that lets a host load a small bank of 8-bit control group registers. It oversamples SCL and SDA with the system clock, finds START and STOP conditions, and checks the 7-bit device address together with the direction bit. An accepted address is followed by one group-code byte and then by data bytes. Each data byte goes to the current group, and the group pointer then advances by one. The host can therefore load several neighbouring groups after naming only the first.

The block never returns data. The only thing it drives onto the bus is the open-drain acknowledge, and it drives that only for bytes it accepts. The register contents are always visible on a flat output vector. Each group also has an update strobe that lasts one system clock and marks the cycle in which a new value appears. At reset every group takes a fixed default value, so the switching logic downstream starts in a known safe setting.

Top module: `ctrl_grp_i2c_target`

## Requirements
- R1: After reset, group k (k = 0..7, where group code k+1 selects group k) holds 8'h80 + k, `sda_oe_o` is 0 and no update strobe is high.
- R2: An address byte whose upper seven bits equal the device address (default 7'b1001000, a parameter) and whose last bit (R/W) is 0 is acknowledged: SDA is held low throughout the ninth SCL high phase.
- R3: An address byte with any other seven-bit address, or with R/W = 1, is not acknowledged. Every later byte up to the next START is then neither acknowledged nor written.
- R4: The byte after an accepted address is a group code. Codes 8'h01 to 8'h08 are acknowledged and select group code-1. Any other code is not acknowledged, and the rest of the transfer is ignored.
- R5: A data byte, received MSB first, is written to the selected group and acknowledged. The group's strobe in `grp_upd_o` is high for exactly one clock, in the first cycle that shows the new value, and at most one strobe is high in any cycle.
- R6: After each data byte the group pointer advances by one. A data byte that arrives when the pointer is already past group code 8'h08 is not acknowledged and not written, and the rest of the transfer is ignored.
- R7: A STOP after a complete data byte keeps every group already written. A START or STOP before the eighth bit of a byte discards that partial byte.
- R8: A repeated START in the middle of a transfer restarts address matching, and the new transfer works the same as one that began after bus idle.
- R9: Transfers work when the host changes SDA in the same instant that SCL falls (zero data hold time).
- R10: `sda_oe_o` is asserted only in the acknowledge slot of an accepted byte. It never rises while SCL is high, and it is low after a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 = pull SDA low (acknowledge), 0 = release |
| grp_regs_o | output | NGRP*8 | Group registers, group k at bits [8k+7:8k] |
| grp_upd_o | output | NGRP | One-clock strobe per group when it is written |

## Verification
The bench drives a single write to one group. This shows whether the group code is decoded and whether the other groups are left alone. A burst that fills all eight groups and then runs one byte past them tests the pointer increment and the limit at the top of the bank. Patterns with a wrong address, R/W set, or an invalid group code (8'h00, 8'h09, 8'h81) test the rejection paths, and the bytes that follow each one show that nothing leaks through. Further patterns with partial bytes cut off by STOP or by a repeated START, and a burst with zero hold time, separate correct condition detection from false START or STOP detection near SCL edges.

// File: rtl/cgt_pkg.sv
package cgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_GRP  = 3'd2,
    ST_DATA = 3'd3,
    ST_SKIP = 3'd4
  } cgt_state_e;

  // Safe reset value of group k: MSB set, low bits carry the index.
  function automatic logic [7:0] grp_default(input int unsigned k);
    return 8'h80 | 8'(k);
  endfunction

endpackage

// File: rtl/cgt_line_sync.sv
module cgt_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_lvl,
  output logic start_det,
  output logic stop_det
);

  // SDA gets one extra stage so a data change made at the SCL fall
  // is always seen after the fall, never as a START or STOP.
  localparam int SDA_LEN = SYNC_STAGES + 1;

  logic [SYNC_STAGES-1:0] scl_chain_q, scl_chain_n;
  logic [SDA_LEN-1:0]     sda_chain_q, sda_chain_n;
  logic                   scl_prev_q, sda_prev_q;

  always_comb begin
    scl_chain_n = {scl_chain_q[SYNC_STAGES-2:0], scl_i};
    sda_chain_n = {sda_chain_q[SDA_LEN-2:0], sda_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_chain_q <= '1;
      sda_chain_q <= '1;
      scl_prev_q  <= 1'b1;
      sda_prev_q  <= 1'b1;
    end else begin
      scl_chain_q <= scl_chain_n;
      sda_chain_q <= sda_chain_n;
      scl_prev_q  <= scl_lvl;
      sda_prev_q  <= sda_lvl;
    end
  end

  assign scl_lvl   = scl_chain_q[SYNC_STAGES-1];
  assign sda_lvl   = sda_chain_q[SDA_LEN-1];
  assign scl_rise  = scl_lvl & ~scl_prev_q;
  assign scl_fall  = ~scl_lvl & scl_prev_q;
  assign start_det = scl_lvl & scl_prev_q & sda_prev_q & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev_q & ~sda_prev_q & sda_lvl;

endmodule

// File: rtl/cgt_proto_fsm.sv
module cgt_proto_fsm
  import cgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1001000,
  parameter int         NGRP     = 8,
  parameter int         GRP_BASE = 1,
  parameter int         IDX_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_lvl,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_lvl,
  input  logic             start_det,
  input  logic             stop_det,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data
);

  localparam int         PTR_W     = $clog2(NGRP + 1);
  localparam logic [7:0] ADDR_BYTE = {DEV_ADDR, 1'b0};
  localparam logic [7:0] GRP_LO    = 8'(GRP_BASE);
  localparam logic [7:0] GRP_HI    = 8'(GRP_BASE + NGRP - 1);
  localparam logic [3:0] CNT_EVAL  = 4'd8;
  localparam logic [3:0] CNT_ACK   = 4'd9;

  cgt_state_e       state_q, state_n;
  logic [3:0]       cnt_q, cnt_n;
  logic [7:0]       shift_q, shift_n;
  logic [PTR_W-1:0] ptr_q, ptr_n;
  logic             oe_q, oe_n;
  logic             wr_en_q, wr_en_n;
  logic [IDX_W-1:0] wr_idx_q, wr_idx_n;
  logic [7:0]       wr_data_q, wr_data_n;
  logic             in_xfer;

  assign in_xfer = (state_q == ST_ADDR) || (state_q == ST_GRP) ||
                   (state_q == ST_DATA);

  always_comb begin
    state_n   = state_q;
    cnt_n     = cnt_q;
    shift_n   = shift_q;
    ptr_n     = ptr_q;
    oe_n      = oe_q;
    wr_en_n   = 1'b0;
    wr_idx_n  = wr_idx_q;
    wr_data_n = wr_data_q;

    if (start_det) begin
      state_n = ST_ADDR;
      cnt_n   = 4'd0;
      oe_n    = 1'b0;
    end else if (stop_det) begin
      state_n = ST_IDLE;
      cnt_n   = 4'd0;
      oe_n    = 1'b0;
    end else if (in_xfer) begin
      if (scl_rise && (cnt_q < CNT_EVAL)) begin
        shift_n = {shift_q[6:0], sda_lvl};
        cnt_n   = cnt_q + 4'd1;
      end else if (scl_fall && (cnt_q == CNT_EVAL)) begin
        cnt_n = CNT_ACK;
        case (state_q)
          ST_ADDR: begin
            if (shift_q == ADDR_BYTE) begin
              oe_n    = 1'b1;
              state_n = ST_GRP;
            end else begin
              state_n = ST_SKIP;
            end
          end
          ST_GRP: begin
            if ((shift_q >= GRP_LO) && (shift_q <= GRP_HI)) begin
              oe_n    = 1'b1;
              ptr_n   = PTR_W'(shift_q - GRP_LO);
              state_n = ST_DATA;
            end else begin
              state_n = ST_SKIP;
            end
          end
          ST_DATA: begin
            if (ptr_q < PTR_W'(NGRP)) begin
              oe_n      = 1'b1;
              wr_en_n   = 1'b1;
              wr_idx_n  = IDX_W'(ptr_q);
              wr_data_n = shift_q;
              ptr_n     = ptr_q + PTR_W'(1);
            end else begin
              state_n = ST_SKIP;
            end
          end
          default: state_n = ST_SKIP;
        endcase
      end else if (scl_fall && (cnt_q == CNT_ACK)) begin
        cnt_n = 4'd0;
        oe_n  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= 4'd0;
      shift_q   <= 8'h00;
      ptr_q     <= '0;
      oe_q      <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_idx_q  <= '0;
      wr_data_q <= 8'h00;
    end else begin
      state_q   <= state_n;
      cnt_q     <= cnt_n;
      shift_q   <= shift_n;
      ptr_q     <= ptr_n;
      oe_q      <= oe_n;
      wr_en_q   <= wr_en_n;
      wr_idx_q  <= wr_idx_n;
      wr_data_q <= wr_data_n;
    end
  end

  assign sda_oe  = oe_q;
  assign wr_en   = wr_en_q;
  assign wr_idx  = wr_idx_q;
  assign wr_data = wr_data_q;

  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> !scl_lvl); // R10

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !oe_q); // R10

  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SKIP) && !start_det |=> !oe_q && !wr_en_q); // R3

  AST_WR_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_q |-> (int'(wr_idx_q) < NGRP)); // R6

endmodule

// File: rtl/cgt_grp_bank.sv
module cgt_grp_bank
  import cgt_pkg::*;
#(
  parameter int NGRP  = 8,
  parameter int IDX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [7:0]        wr_data,
  output logic [NGRP*8-1:0] regs_o,
  output logic [NGRP-1:0]   upd_o
);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [7:0] val_q;
    logic       load;
    logic       upd_q;

    assign load = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= grp_default(g);
      end else if (load) begin
        val_q <= wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        upd_q <= 1'b0;
      end else begin
        upd_q <= load;
      end
    end

    assign regs_o[g*8 +: 8] = val_q;
    assign upd_o[g]         = upd_q;
  end

  AST_UPD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upd_o)); // R5

endmodule

// File: rtl/ctrl_grp_i2c_target.sv
module ctrl_grp_i2c_target #(
  parameter logic [6:0] DEV_ADDR    = 7'b1001000,
  parameter int         NGRP        = 8,
  parameter int         GRP_BASE    = 1,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [NGRP*8-1:0] grp_regs_o,
  output logic [NGRP-1:0]   grp_upd_o
);

  localparam int IDX_W = (NGRP > 1) ? $clog2(NGRP) : 1;

  logic             scl_lvl, scl_rise, scl_fall, sda_lvl;
  logic             start_det, stop_det;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0]       wr_data;

  cgt_line_sync #(
    .SYNC_STAGES (SYNC_STAGES)
  ) sync_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_lvl   (scl_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_lvl   (sda_lvl),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  cgt_proto_fsm #(
    .DEV_ADDR (DEV_ADDR),
    .NGRP     (NGRP),
    .GRP_BASE (GRP_BASE),
    .IDX_W    (IDX_W)
  ) fsm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_lvl   (scl_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_lvl   (sda_lvl),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe_o),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data)
  );

  cgt_grp_bank #(
    .NGRP  (NGRP),
    .IDX_W (IDX_W)
  ) bank_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .regs_o  (grp_regs_o),
    .upd_o   (grp_upd_o)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_chk
    AST_COMMIT_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && (wr_idx == IDX_W'(g)) |=>
        grp_upd_o[g] && (grp_regs_o[g*8 +: 8] == $past(wr_data))); // R5
  end

endmodule

// File: tb/ctrl_grp_i2c_target_tb_top.sv
`timescale 1ns/1ps
module ctrl_grp_i2c_target_tb_top;

  localparam int NG = 8;
  localparam int TQ = 200;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          h_sda_low = 1'b0;
  logic          h_scl_low = 1'b0;
  logic          sda_bus, scl_bus;
  logic          sda_oe;
  logic [NG*8-1:0] regs;
  logic [NG-1:0] upd;

  int checks = 0;
  int fails = 0;
  int hold_t = TQ;
  bit done = 1'b0;

  logic [7:0] exp_reg [NG];
  int         exp_cnt [NG];
  int         upd_cnt [NG];
  logic [7:0] upd_val [NG];
  logic [NG-1:0] upd_prev = '0;
  logic       oe_prev = 1'b0;
  int         dbl_pulse = 0;
  int         oe_bad = 0;

  always #4 clk = ~clk;

  assign scl_bus = ~h_scl_low;
  assign sda_bus = ~(h_sda_low | sda_oe);

  ctrl_grp_i2c_target dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_bus),
    .sda_i      (sda_bus),
    .sda_oe_o   (sda_oe),
    .grp_regs_o (regs),
    .grp_upd_o  (upd)
  );

  // Strobe and acknowledge monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < NG; k++) begin
        if (upd[k]) begin
          upd_cnt[k] = upd_cnt[k] + 1;
          upd_val[k] = regs[k*8 +: 8];
          if (upd_prev[k]) dbl_pulse = dbl_pulse + 1;
        end
      end
      if (sda_oe && !oe_prev && scl_bus) oe_bad = oe_bad + 1;
      upd_prev = upd;
      oe_prev  = sda_oe;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_regs(input string req);
    for (int k = 0; k < NG; k++) begin
      chk(req, $sformatf("group %0d value", k), int'(regs[k*8 +: 8]), int'(exp_reg[k]));
      chk(req, $sformatf("group %0d strobes", k), upd_cnt[k], exp_cnt[k]);
    end
  endtask

  task automatic bus_start();
    h_sda_low = 1'b0; #(TQ);
    h_scl_low = 1'b0; #(TQ);
    h_sda_low = 1'b1; #(TQ);
    h_scl_low = 1'b1; #(TQ);
  endtask

  task automatic bus_stop();
    h_sda_low = 1'b1; #(TQ);
    h_scl_low = 1'b0; #(TQ);
    h_sda_low = 1'b0; #(2*TQ);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i >= 8 - n; i--) begin
      h_sda_low = ~b[i]; #(TQ);
      h_scl_low = 1'b0;  #(2*TQ);
      h_scl_low = 1'b1;  #(hold_t);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    h_sda_low = 1'b0; #(TQ);
    h_scl_low = 1'b0; #(TQ);
    ack = (sda_bus == 1'b0);
    #(TQ);
    h_scl_low = 1'b1; #(hold_t);
  endtask

  function automatic logic [7:0] burst_val(input int k);
    return 8'((k * 29 + 7) ^ 8'h5A);
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic a;
    for (int k = 0; k < NG; k++) begin
      exp_reg[k] = 8'h80 + 8'(k);
      exp_cnt[k] = 0;
      upd_cnt[k] = 0;
      upd_val[k] = 8'h00;
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk_regs("R1");
    chk("R1", "sda_oe after reset", int'(sda_oe), 0);
    chk("R1", "strobes after reset", int'(upd), 0);

    // R2 / R5: single write to group code 3
    bus_start();
    send_byte({7'b1001000, 1'b0}, a); chk("R2", "address ack", int'(a), 1);
    send_byte(8'h03, a);              chk("R4", "group 3 ack", int'(a), 1);
    send_byte(8'hA5, a);              chk("R5", "data ack", int'(a), 1);
    bus_stop();
    exp_reg[2] = 8'hA5; exp_cnt[2]++;
    chk_regs("R5");
    chk("R5", "strobe shows new value", int'(upd_val[2]), 8'hA5);

    // R6: burst over all groups, then one byte past the last
    bus_start();
    send_byte({7'b1001000, 1'b0}, a); chk("R2", "address ack burst", int'(a), 1);
    send_byte(8'h01, a);              chk("R4", "group 1 ack", int'(a), 1);
    for (int k = 0; k < NG; k++) begin
      send_byte(burst_val(k), a);
      chk("R6", $sformatf("burst byte %0d ack", k), int'(a), 1);
      exp_reg[k] = burst_val(k); exp_cnt[k]++;
    end
    send_byte(8'hFF, a); chk("R6", "byte past last group ack", int'(a), 0);
    send_byte(8'h00, a); chk("R6", "byte after overrun ack", int'(a), 0);
    bus_stop();
    chk_regs("R6");

    // R6: start near the top
    bus_start();
    send_byte({7'b1001000, 1'b0}, a);
    send_byte(8'h07, a);  chk("R4", "group 7 ack", int'(a), 1);
    send_byte(8'h11, a);  chk("R6", "group 7 data ack", int'(a), 1);
    send_byte(8'h22, a);  chk("R6", "group 8 data ack", int'(a), 1);
    send_byte(8'h33, a);  chk("R6", "overflow data ack", int'(a), 0);
    bus_stop();
    exp_reg[6] = 8'h11; exp_cnt[6]++;
    exp_reg[7] = 8'h22; exp_cnt[7]++;
    chk_regs("R6");

    // R3: mismatched addresses
    bus_start();
    send_byte({7'b1001001, 1'b0}, a); chk("R3", "wrong address ack", int'(a), 0);
    send_byte(8'h02, a);              chk("R3", "group after wrong addr", int'(a), 0);
    send_byte(8'h5C, a);              chk("R3", "data after wrong addr", int'(a), 0);
    bus_stop();
    bus_start();
    send_byte({7'b0100100, 1'b0}, a); chk("R3", "shifted address ack", int'(a), 0);
    send_byte(8'h02, a);              chk("R3", "group after shifted addr", int'(a), 0);
    bus_stop();
    // R3: read direction
    bus_start();
    send_byte({7'b1001000, 1'b1}, a); chk("R3", "read request ack", int'(a), 0);
    send_byte(8'h02, a);              chk("R3", "group after read", int'(a), 0);
    send_byte(8'h6D, a);              chk("R3", "data after read", int'(a), 0);
    bus_stop();
    chk_regs("R3");

    // R4: invalid group codes
    foreach (exp_cnt[i]) begin end
    for (int j = 0; j < 3; j++) begin
      logic [7:0] code;
      code = (j == 0) ? 8'h00 : (j == 1) ? 8'h09 : 8'h81;
      bus_start();
      send_byte({7'b1001000, 1'b0}, a);
      send_byte(code, a); chk("R4", $sformatf("invalid code %0h ack", code), int'(a), 0);
      send_byte(8'h4E, a); chk("R4", "data after invalid code", int'(a), 0);
      bus_stop();
    end
    chk_regs("R4");

    // R7: partial byte cut by STOP
    bus_start();
    send_byte({7'b1001000, 1'b0}, a);
    send_byte(8'h04, a);
    send_byte(8'hC3, a); chk("R7", "full byte ack", int'(a), 1);
    send_bits(8'h0F, 4);
    bus_stop();
    exp_reg[3] = 8'hC3; exp_cnt[3]++;
    chk_regs("R7");

    // R7 / R8: partial byte cut by repeated START, then new transfer
    bus_start();
    send_byte({7'b1001000, 1'b0}, a);
    send_byte(8'h06, a);
    send_bits(8'hE1, 5);
    bus_start();
    send_byte({7'b1001000, 1'b0}, a); chk("R8", "address after rep start", int'(a), 1);
    send_byte(8'h06, a);              chk("R8", "group after rep start", int'(a), 1);
    send_byte(8'h96, a);              chk("R8", "data after rep start", int'(a), 1);
    bus_stop();
    exp_reg[5] = 8'h96; exp_cnt[5]++;
    chk_regs("R8");

    // R8: repeated START between two complete writes, then a bad address
    bus_start();
    send_byte({7'b1001000, 1'b0}, a);
    send_byte(8'h05, a);
    send_byte(8'h3A, a);
    bus_start();
    send_byte({7'b1001000, 1'b0}, a);
    send_byte(8'h08, a);
    send_byte(8'hB7, a); chk("R8", "second write ack", int'(a), 1);
    bus_start();
    send_byte({7'b1011000, 1'b0}, a); chk("R8", "bad addr after rep start", int'(a), 0);
    send_byte(8'h01, a);              chk("R8", "group after bad rep addr", int'(a), 0);
    bus_stop();
    exp_reg[4] = 8'h3A; exp_cnt[4]++;
    exp_reg[7] = 8'hB7; exp_cnt[7]++;
    chk_regs("R8");

    // R9: zero hold time
    hold_t = 0;
    bus_start();
    send_byte({7'b1001000, 1'b0}, a); chk("R9", "address ack zero hold", int'(a), 1);
    send_byte(8'h02, a);              chk("R9", "group ack zero hold", int'(a), 1);
    send_byte(8'h69, a);              chk("R9", "data1 ack zero hold", int'(a), 1);
    send_byte(8'h96, a);              chk("R9", "data2 ack zero hold", int'(a), 1);
    send_byte(8'h0F, a);              chk("R9", "data3 ack zero hold", int'(a), 1);
    bus_stop();
    hold_t = TQ;
    exp_reg[1] = 8'h69; exp_cnt[1]++;
    exp_reg[2] = 8'h96; exp_cnt[2]++;
    exp_reg[3] = 8'h0F; exp_cnt[3]++;
    chk_regs("R9");

    // R7: STOP right after the group code writes nothing
    bus_start();
    send_byte({7'b1001000, 1'b0}, a);
    send_byte(8'h03, a);
    bus_stop();
    chk_regs("R7");

    // R10 and R5 global observations
    repeat (4) @(negedge clk);
    chk("R10", "sda_oe after stop", int'(sda_oe), 0);
    chk("R10", "sda_oe rises with SCL high", oe_bad, 0);
    chk("R5", "strobe longer than one clock", dbl_pulse, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule